// File: doc/BRIEF.md
# I2C Master for Paired-Register Targets with Post-Acknowledge Quiet Gaps

This block is an I2C bus master for targets that only exchange data as 16-bit register pairs and that need the bus left completely idle for a while after every acknowledge slot. A host hands it one command at a time: a 7-bit target address, a read/write flag and a 16-bit word to write. The controller then runs a full transaction with exactly two data bytes and returns the 16-bit word read, a done pulse and an address-NACK flag.

After the falling SCL edge that ends each ninth clock pulse, the controller holds both lines still for a programmable number of system clock cycles. This also happens after the NACK that closes a read and before STOP. A read NACKs its second byte, waits out the gap, and then issues STOP directly, with no further clock pulse. The outputs are open-drain enables: a 1 on an enable pulls that line low.

Top module: `i2c_pair_master`

## Requirements
- R1: After reset, both line enables are 0 (bus released), busy_o is 0 and done_o is 0.
- R2: A command on start_i is accepted only while busy_o is 0. A start_i pulse while busy_o is 1 has no effect on the running transaction and does not cause a second one.
- R3: Every transaction is START, one address byte equal to {addr_i, rnw_i} (rnw_i=1 for read), two data bytes, then STOP. That is 27 SCL pulses when the address is acknowledged. Bits go MSB first.
- R4: A write sends wdata_i[15:8] as the first data byte and wdata_i[7:0] as the second.
- R5: A read places the first received byte in rdata_o[15:8] and the second in rdata_o[7:0]. The master drives SDA low (ACK) in the ninth slot of the first byte and releases it (NACK) in the ninth slot of the second byte. No SCL pulse follows that NACK.
- R6: After each SCL fall that ends a ninth clock pulse, neither SCL nor SDA changes for at least GAP_CYCLES system clock cycles. This includes the gap before STOP.
- R7: SDA changes while SCL is high only for START (SDA falls) and STOP (SDA rises).
- R8: If the address byte is not acknowledged (SDA high in its ninth slot), no data bytes are sent. The gap is inserted, STOP is issued, and nack_o is 1 in the same cycle as done_o.
- R9: busy_o is 1 from the cycle after acceptance until STOP has completed. done_o is a one-cycle pulse, and busy_o is already 0 in that cycle.
- R10: Each SCL high time inside a transaction lasts exactly 2*QTR_CYCLES system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| rnw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 7 | Target address |
| wdata_i | input | 16 | Word to write, high byte first |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| rdata_o | output | 16 | Word read, valid at done_o |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| nack_o | output | 1 | Address not acknowledged, valid with done_o |

## Verification
The bench builds the block with QTR_CYCLES=2 and GAP_CYCLES=13. A whole transaction then fits in a few hundred cycles, so it can sweep ten data words through both writes and reads. A bus-level target model answers at address 0x22. A bus monitor measures every high time, every post-acknowledge quiet window and every SDA edge made while SCL is high. The short gap makes it cheap to see each of the three gaps per transaction, including the final one before STOP. A command to an absent address exercises the NACK path, and a start strobe issued mid-transaction checks that commands are ignored while busy.

// File: rtl/i2c_pair_pkg.sv
package i2c_pair_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_GAP,
    ST_STOP_A,
    ST_STOP_B,
    ST_STOP_C
  } state_e;

  localparam int unsigned ACK_SLOT  = 8;
  localparam int unsigned LAST_BYTE = 2;
endpackage

// File: rtl/i2c_pair_tick.sv
module i2c_pair_tick #(
  parameter int unsigned QTR_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = !clear_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/i2c_pair_gap.sv
module i2c_pair_gap #(
  parameter int unsigned GAP_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(GAP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  AST_GAP_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GAP_CYCLES > 1 && $rose(run_i)) |-> !expired_o); // R6
endmodule

// File: rtl/i2c_pair_master.sv
module i2c_pair_master
  import i2c_pair_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned QTR_CYCLES = 125,
  parameter int unsigned GAP_CYCLES = (CLK_HZ / 1_000_000) * 15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rnw_i,
  input  logic [6:0]  addr_i,
  input  logic [15:0] wdata_i,
  input  logic        sda_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  output logic [15:0] rdata_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        nack_o
);
  localparam logic [3:0] ACK_BIT  = 4'(ACK_SLOT);
  localparam logic [1:0] LAST_BY  = 2'(LAST_BYTE);

  state_e      state_q;
  logic [1:0]  phase_q, byte_q;
  logic [3:0]  bit_q;
  logic [7:0]  tx_q, tx_nxt;
  logic [6:0]  addr_q;
  logic        rnw_q, anack_q;
  logic [15:0] wdata_q, rx_q;
  logic        scl_oe_q, sda_oe_q, done_q, err_q;
  logic        tick, gap_done;

  i2c_pair_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_q == ST_IDLE || state_q == ST_GAP),
    .tick_o  (tick)
  );

  i2c_pair_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_GAP),
    .expired_o (gap_done)
  );

  // pull-low request for a given slot; read data bits and final NACK release the line
  function automatic logic sda_drive(logic [1:0] by, logic [3:0] bi, logic msb, logic rd);
    if (bi == ACK_BIT) return rd && (by == 2'd1);
    return !(rd && by != 2'd0) && !msb;
  endfunction

  assign tx_nxt = (byte_q == 2'd0) ? wdata_q[15:8] : wdata_q[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      phase_q  <= '0;
      bit_q    <= '0;
      byte_q   <= '0;
      tx_q     <= '0;
      addr_q   <= '0;
      rnw_q    <= 1'b0;
      wdata_q  <= '0;
      rx_q     <= '0;
      anack_q  <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q   <= addr_i;
          rnw_q    <= rnw_i;
          wdata_q  <= wdata_i;
          anack_q  <= 1'b0;
          rx_q     <= '0;
          sda_oe_q <= 1'b1;             // START: SDA falls, SCL high
          phase_q  <= '0;
          state_q  <= ST_START;
        end
        ST_START: if (tick) begin
          if (phase_q == 2'd0) begin
            scl_oe_q <= 1'b1;
            phase_q  <= 2'd1;
          end else begin
            state_q  <= ST_BIT;
            phase_q  <= '0;
            bit_q    <= '0;
            byte_q   <= '0;
            tx_q     <= {addr_q, rnw_q};
            sda_oe_q <= sda_drive(2'd0, 4'd0, addr_q[6], rnw_q);
          end
        end
        ST_BIT: if (tick) begin
          case (phase_q)
            2'd0: begin
              scl_oe_q <= 1'b0;
              phase_q  <= 2'd1;
            end
            2'd1: phase_q <= 2'd2;
            2'd2: begin
              if (bit_q == ACK_BIT) begin
                if (byte_q == 2'd0) anack_q <= sda_i;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0};
                if (rnw_q && byte_q != 2'd0) rx_q <= {rx_q[14:0], sda_i};
              end
              scl_oe_q <= 1'b1;
              phase_q  <= 2'd3;
            end
            default: begin
              if (bit_q == ACK_BIT) begin
                state_q <= ST_GAP;
              end else begin
                bit_q    <= bit_q + 4'd1;
                phase_q  <= '0;
                sda_oe_q <= sda_drive(byte_q, bit_q + 4'd1, tx_q[7], rnw_q);
              end
            end
          endcase
        end
        ST_GAP: if (gap_done) begin
          if (anack_q || byte_q == LAST_BY) begin
            sda_oe_q <= 1'b1;           // SDA low under SCL low before STOP
            state_q  <= ST_STOP_A;
          end else begin
            byte_q   <= byte_q + 2'd1;
            bit_q    <= '0;
            phase_q  <= '0;
            tx_q     <= tx_nxt;
            sda_oe_q <= sda_drive(byte_q + 2'd1, 4'd0, tx_nxt[7], rnw_q);
            state_q  <= ST_BIT;
          end
        end
        ST_STOP_A: if (tick) begin
          scl_oe_q <= 1'b0;
          state_q  <= ST_STOP_B;
        end
        ST_STOP_B: if (tick) begin
          sda_oe_q <= 1'b0;             // STOP: SDA rises, SCL high
          state_q  <= ST_STOP_C;
        end
        ST_STOP_C: if (tick) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          err_q   <= anack_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;
  assign rdata_o  = rx_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign nack_o   = err_q;

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(addr_q) && $stable(rnw_q) && $stable(wdata_q))); // R2
  AST_GAP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && $past(state_q) == ST_GAP) |-> ($stable(scl_oe_q) && $stable(sda_oe_q))); // R6
  AST_SDA_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_q && !$past(scl_oe_q) && (sda_oe_q != $past(sda_oe_q)))
      |-> (state_q == ST_START || state_q == ST_STOP_C)); // R7
  AST_NACK_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
endmodule

// File: tb/i2c_pair_master_bench.sv
module i2c_pair_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 2;
  localparam int GAP = 13;
  localparam logic [6:0] TGT = 7'h22;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, rnw_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic scl_oe, sda_oe, busy_o, done_o, nack_o;
  logic [15:0] rdata_o;
  logic slv_low = 1'b0;
  logic scl, sda_line;

  assign scl = !scl_oe;
  assign sda_line = !(sda_oe || slv_low);

  always #(CLK_PERIOD/2) clk = !clk;

  i2c_pair_master #(.CLK_HZ(1_000_000), .QTR_CYCLES(QTR), .GAP_CYCLES(GAP)) u_i2c_pair_master (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rnw_i(rnw_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .rdata_o(rdata_o), .busy_o(busy_o), .done_o(done_o), .nack_o(nack_o)
  );

  int n_tests = 0, n_fail = 0;

  // ---- target model at address TGT ----
  int s_bit = 0, s_byte = 0, s_starts = 0, s_stops = 0;
  logic s_pending = 1'b0, s_sel = 1'b0, s_rd = 1'b0, s_mack0 = 1'b0, s_mack1 = 1'b0;
  logic [7:0] s_sh = '0, s_abyte = '0, s_rx1 = '0, s_rx2 = '0;
  logic [15:0] s_word = '0;

  always @(negedge sda_line) if (scl === 1'b1) begin
    s_starts++; s_pending = 1'b1; s_bit = 0; s_byte = 0; s_sel = 1'b0; slv_low = 1'b0;
  end
  always @(posedge sda_line) if (scl === 1'b1) s_stops++;

  always @(posedge scl) begin
    if (s_bit < 8) s_sh = {s_sh[6:0], sda_line};
    else if (s_sel && s_rd && s_byte == 1) s_mack0 = sda_line;
    else if (s_sel && s_rd && s_byte == 2) s_mack1 = sda_line;
  end

  always @(negedge scl) begin
    int idx;
    if (s_pending) s_pending = 1'b0;
    else begin
      s_bit++;
      if (s_bit == 8) begin
        if (s_byte == 0) begin s_abyte = s_sh; s_sel = (s_sh[7:1] == TGT); s_rd = s_sh[0]; end
        else if (!s_rd && s_byte == 1) s_rx1 = s_sh;
        else if (!s_rd && s_byte == 2) s_rx2 = s_sh;
      end
      if (s_bit == 9) begin s_bit = 0; s_byte++; end
    end
    slv_low = 1'b0;
    if (s_sel) begin
      if (s_bit == 8 && (s_byte == 0 || !s_rd)) slv_low = 1'b1;
      else if (s_rd && s_byte >= 1 && s_byte <= 2 && s_bit < 8) begin
        idx = ((s_byte == 1) ? 15 : 7) - s_bit;
        slv_low = !s_word[idx];
      end
    end
  end

  // ---- bus monitor ----
  int cyc = 0, arm_cyc = 0, rise_cyc = 0;
  int m_bits = 0, m_bits_tot = 0, m_windows = 0, m_gap_bad = 0, m_sda_bad = 0, m_high_bad = 0;
  logic p_scl = 1'b1, p_sda = 1'b1, armed = 1'b0, m_in_txn = 1'b0, m_first_fall = 1'b0;

  always @(negedge clk) begin
    logic c_scl, c_sda;
    cyc++;
    c_scl = scl; c_sda = sda_line;
    if (rst_ni) begin
      if ((c_scl != p_scl) || (c_sda != p_sda)) begin
        if (armed) begin m_windows++; if (cyc - arm_cyc < GAP) m_gap_bad++; armed = 1'b0; end
      end
      if (p_scl && c_scl && (c_sda != p_sda)) begin
        if (!c_sda) begin
          if (m_in_txn) m_sda_bad++;
          m_in_txn = 1'b1; m_first_fall = 1'b1; m_bits = 0;
        end else begin
          if (!m_in_txn) m_sda_bad++;
          m_in_txn = 1'b0;
        end
      end
      if (!p_scl && c_scl) rise_cyc = cyc;
      if (p_scl && !c_scl) begin
        if (m_first_fall) m_first_fall = 1'b0;
        else begin
          m_bits++; m_bits_tot++;
          if (cyc - rise_cyc != 2*QTR) m_high_bad++;
          if (m_bits % 9 == 0) begin armed = 1'b1; arm_cyc = cyc; end
        end
      end
      p_scl = c_scl; p_sda = c_sda;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int i);
    if (i == 0) return 16'h0000;
    if (i == 1) return 16'hFFFF;
    return 16'((i * 16'hA5C3) ^ (16'h0101 << i));
  endfunction

  int b_st, b_sp, b_bits, b_win, b_gap, b_sda, b_high;
  logic got_done, got_nack, got_busy;
  logic [15:0] got_rd;

  task automatic snap();
    b_st = s_starts; b_sp = s_stops; b_bits = m_bits_tot; b_win = m_windows;
    b_gap = m_gap_bad; b_sda = m_sda_bad; b_high = m_high_bad;
  endtask

  // issue at a negedge; optional_pulse_at > 0 issues a second strobe mid-transaction
  task automatic run_cmd(input logic [6:0] a, input logic rd, input logic [15:0] wd, input int pulse_at);
    snap();
    addr_i = a; rnw_i = rd; wdata_i = wd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy after accept", busy_o, 1);
    got_done = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (pulse_at > 0 && i == pulse_at) begin
        addr_i = 7'h22; rnw_i = !rd; wdata_i = ~wd; start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk);
      if (done_o) begin got_done = 1'b1; break; end
      if (!busy_o) begin check(1'b0, "R9 busy dropped before done", 0, 1); break; end
    end
    start_i = 1'b0;
    got_nack = nack_o; got_busy = busy_o; got_rd = rdata_o;
    check(got_done, "R9 done seen", got_done, 1);
    check(!got_busy, "R9 busy low with done", got_busy, 0);
    @(negedge clk);
    check(!done_o, "R9 done one cycle", done_o, 0);
  endtask

  task automatic common_checks(input int exp_bits, input int exp_win);
    check(s_starts - b_st == 1, "R3 one START", s_starts - b_st, 1);
    check(s_stops - b_sp == 1, "R3 one STOP", s_stops - b_sp, 1);
    check(m_bits_tot - b_bits == exp_bits, "R3 SCL pulses", m_bits_tot - b_bits, exp_bits);
    check(m_windows - b_win == exp_win, "R6 gap windows", m_windows - b_win, exp_win);
    check(m_gap_bad == b_gap, "R6 gap too short", m_gap_bad - b_gap, 0);
    check(m_sda_bad == b_sda, "R7 SDA edge under SCL high", m_sda_bad - b_sda, 0);
    check(m_high_bad == b_high, "R10 SCL high time", m_high_bad - b_high, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released", {scl_oe, sda_oe}, 0);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1 busy/done low", {busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 10; i++) begin : g_wr
      logic [15:0] w;
      w = pattern(i);
      run_cmd(TGT, 1'b0, w, 0);
      check(s_abyte == 8'h44, "R3 write address byte", s_abyte, 8'h44);
      check(s_rx1 == w[15:8], "R4 first byte", s_rx1, w[15:8]);
      check(s_rx2 == w[7:0], "R4 second byte", s_rx2, w[7:0]);
      check(!got_nack, "R8 no nack on write", got_nack, 0);
      common_checks(27, 3);
      repeat (5) @(negedge clk);
    end

    for (int i = 0; i < 10; i++) begin : g_rd
      logic [15:0] w;
      w = pattern(9 - i) ^ 16'h3C00;
      s_word = w;
      run_cmd(TGT, 1'b1, 16'h0000, 0);
      check(s_abyte == 8'h45, "R3 read address byte", s_abyte, 8'h45);
      check(got_rd == w, "R5 read word order", got_rd, w);
      check(s_mack0 == 1'b0, "R5 ACK after first byte", s_mack0, 0);
      check(s_mack1 == 1'b1, "R5 NACK after second byte", s_mack1, 1);
      check(!got_nack, "R8 no nack on read", got_nack, 0);
      common_checks(27, 3);
      repeat (5) @(negedge clk);
    end

    // R8 absent target
    run_cmd(7'h23, 1'b0, 16'hBEEF, 0);
    check(got_nack, "R8 nack flag with done", got_nack, 1);
    common_checks(9, 1);
    repeat (5) @(negedge clk);
    run_cmd(7'h23, 1'b1, 16'h0000, 0);
    check(got_nack, "R8 nack flag on read", got_nack, 1);
    common_checks(9, 1);
    repeat (5) @(negedge clk);

    // R2 strobe while busy is ignored
    run_cmd(TGT, 1'b0, 16'h6A95, 60);
    check(s_rx1 == 8'h6A && s_rx2 == 8'h95, "R2 data unaffected", {s_rx1, s_rx2}, 16'h6A95);
    common_checks(27, 3);
    repeat (20) @(negedge clk);
    check(!busy_o && !scl_oe && !sda_oe, "R2 no second transaction", {busy_o, scl_oe, sda_oe}, 0);
    check(s_starts - b_st == 1, "R2 single START", s_starts - b_st, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule